// File: doc/BRIEF.md
# Three-Wire Serial Memory Host Controller

This block is the host side of a serial link to a 128-word by 16-bit electrically erasable memory that uses a select line, a clock, and separate data lines in each direction. A command enters on a valid/ready handshake. The command carries an operation, a 7-bit word address, a 16-bit write word and a word count for streamed reads. The block builds the serial frame and shifts it out most significant bit first. It produces the serial clock from a divider counted in system clocks. Read words come back one at a time on a single-cycle strobe.

Programming commands are write word, erase word, erase all and write all. After one of these, the block drops select for a minimum low time. It then raises select and samples the return line until the memory reports ready. It clocks one release bit before it closes the transaction. If ready never comes, a bounded poll raises an error flag.

The command port obeys back-pressure: `cmd_ready` is high only in idle, and a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The read word output has no back-pressure. Each word is presented for exactly one cycle and the consumer must take it.

Top module: `mw_host`

## Requirements
- R1: After reset, `mw_cs`, `mw_sk`, `mw_di`, `rd_valid` and `err_timeout` are low and `cmd_ready` is high.
- R2: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` high. `cmd_ready` falls on the next cycle and stays low until the command, including its closing select-low gap, is complete.
- R3: Each frame starts with a 1, followed by a 2-bit opcode (read 10, write 01, erase 11) and an 8-bit address field equal to {0, address[6:0]}, all MSB first. `mw_di` changes only while `mw_sk` is low, so it is stable at each rising edge. Operation codes on `cmd_op`: 0 read, 1 write, 2 erase, 3 enable programming, 4 disable programming, 5 erase all, 6 write all; 7 behaves as 4.
- R4: Enable, disable, erase all and write all send opcode 00 with address field bits [7:6] equal to 11, 00, 10 and 01 respectively and zeros below. A write sent while programming is disabled leaves the memory unchanged.
- R5: Write and write all append the 16-bit data word MSB first, giving 27 clocked bits. All other frames other than read clock 11 bits.
- R6: A read discards the first returned bit, then captures 16 bits MSB first per word. Select stays high for all N words of a `cmd_count`=N request, with no discarded bit between words. A count of 0 reads one word. Each word gives a one-cycle `rd_valid` pulse.
- R7: `mw_sk` has a half period of HALF_CYC system clocks and is only ever high while `mw_cs` is high.
- R8: After a programming frame, select stays low for at least CSMIN_CYC cycles. It then rises, and `mw_do` is sampled once every HALF_CYC cycles until it reads 1.
- R9: Once ready is seen, exactly one `mw_sk` pulse is made with `mw_di` high, and then select drops.
- R10: If POLL_MAX samples in a row read 0, `err_timeout` is set, select drops with no release pulse and the command completes. The next accepted command clears `err_timeout`.
- R11: Read, enable and disable use a single select-high session and no poll. Select then stays low for at least CSMIN_CYC cycles before `cmd_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R3) |
| cmd_addr | input | 7 | Word address |
| cmd_wdata | input | 16 | Data for write and write all |
| cmd_count | input | CNT_W | Words to read, 0 means 1 |
| rd_valid | output | 1 | One-cycle strobe per captured word |
| rd_data | output | 16 | Captured read word |
| err_timeout | output | 1 | Poll ran out without ready |
| mw_cs | output | 1 | Memory select |
| mw_sk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data to memory |
| mw_do | input | 1 | Serial data from memory |

## Verification
The bench builds the controller with HALF_CYC=2, CSMIN_CYC=3 and POLL_MAX=16. It pairs it with a behavioural memory whose busy time is 20 system clocks. With these values a normal program cycle ends after about ten polls. A stuck memory exhausts the poll budget within 32 cycles, so both the ready path and the timeout path are reached in a short run. CNT_W=8 allows one 128-word read, which walks the whole array and wraps through address 0. The bench also runs streamed reads that start at 126.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int AF_W    = ADDR_W + 1;
  localparam int HDR_W   = 3 + AF_W;
  localparam int FRAME_W = HDR_W + DATA_W;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WREN  = 3'd3,
    OP_WRDIS = 3'd4,
    OP_ERALL = 3'd5,
    OP_WRALL = 3'd6
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP_PROG,
    ST_POLL,
    ST_REL,
    ST_GAP_END
  } mw_state_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SEL_WREN  = 2'b11;
  localparam logic [1:0] SEL_WRDIS = 2'b00;
  localparam logic [1:0] SEL_ERALL = 2'b10;
  localparam logic [1:0] SEL_WRALL = 2'b01;
endpackage

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [2:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               is_read,
  output logic               is_prog
);
  logic [1:0]      opc;
  logic [AF_W-1:0] afield;
  logic            with_data;

  always_comb begin
    opc       = OPC_EXT;
    afield    = '0;
    with_data = 1'b0;
    is_read   = 1'b0;
    is_prog   = 1'b0;
    case (op)
      OP_READ: begin
        opc     = OPC_READ;
        afield  = {1'b0, addr};
        is_read = 1'b1;
      end
      OP_WRITE: begin
        opc       = OPC_WRITE;
        afield    = {1'b0, addr};
        with_data = 1'b1;
        is_prog   = 1'b1;
      end
      OP_ERASE: begin
        opc     = OPC_ERASE;
        afield  = {1'b0, addr};
        is_prog = 1'b1;
      end
      OP_WREN: afield = {SEL_WREN, {(AF_W-2){1'b0}}};
      OP_ERALL: begin
        afield  = {SEL_ERALL, {(AF_W-2){1'b0}}};
        is_prog = 1'b1;
      end
      OP_WRALL: begin
        afield    = {SEL_WRALL, {(AF_W-2){1'b0}}};
        with_data = 1'b1;
        is_prog   = 1'b1;
      end
      default: afield = {SEL_WRDIS, {(AF_W-2){1'b0}}};
    endcase
    frame = {1'b1, opc, afield, (with_data ? wdata : {DATA_W{1'b0}})};
    len   = with_data ? LEN_W'(FRAME_W) : LEN_W'(HDR_W);
  end
endmodule

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(HALF_CYC + 1);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + W'(1);
  end

  // R7: one tick per half period, never back to back
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/mw_word_deser.sv
module mw_word_deser #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  localparam int CW = $clog2(DATA_W);
  logic [DATA_W-1:0] sr_q;
  logic [CW-1:0]     cnt_q;
  logic              skip_q;
  logic [DATA_W-1:0] next_sr;

  assign next_sr = {sr_q[DATA_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      skip_q     <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (start) begin
      cnt_q      <= '0;
      skip_q     <= 1'b1;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (sample) begin
        if (skip_q) skip_q <= 1'b0;
        else begin
          sr_q <= next_sr;
          if (cnt_q == CW'(DATA_W - 1)) begin
            cnt_q      <= '0;
            word_valid <= 1'b1;
            word_data  <= next_sr;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end

  // R6: every word strobe lasts a single cycle
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int CSMIN_CYC = 8,
  parameter int POLL_MAX  = 1024,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_timeout,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int TXC_W = $clog2(FRAME_W + 1);
  localparam int RXC_W = $clog2(DATA_W * (2 ** CNT_W) + 2);
  localparam int GAP_W = $clog2(CSMIN_CYC + 1);
  localparam int PC_W  = $clog2(POLL_MAX + 1);

  mw_state_e          state_q;
  logic [FRAME_W-1:0] tx_q, f_bits;
  logic [TXC_W-1:0]   tx_left_q, f_len;
  logic [RXC_W-1:0]   rx_left_q, rx_total;
  logic [GAP_W-1:0]   gap_q;
  logic [PC_W-1:0]    poll_q;
  logic [CNT_W-1:0]   words;
  logic sk_q, cs_q, prog_q, rd_q, err_q;
  logic f_rd, f_prog, tick, tmr_run, accept, last_bit, rx_sample;

  mw_frame #(.LEN_W(TXC_W)) u_frame (
    .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata),
    .frame(f_bits), .len(f_len), .is_read(f_rd), .is_prog(f_prog)
  );

  assign tmr_run = (state_q == ST_SHIFT) || (state_q == ST_POLL) || (state_q == ST_REL);

  mw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .tick(tick)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign words     = (cmd_count == '0) ? CNT_W'(1) : cmd_count;
  assign rx_total  = RXC_W'(1) + RXC_W'(DATA_W) * RXC_W'(words);
  assign last_bit  = ((tx_left_q == TXC_W'(1)) && (rx_left_q == '0)) ||
                     ((tx_left_q == '0) && (rx_left_q == RXC_W'(1)));
  assign rx_sample = (state_q == ST_SHIFT) && tick && !sk_q && rd_q &&
                     (tx_left_q == '0) && (rx_left_q != '0);

  mw_word_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .start(accept && f_rd), .sample(rx_sample),
    .bit_in(mw_do), .word_valid(rd_valid), .word_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tx_q      <= '0;
      tx_left_q <= '0;
      rx_left_q <= '0;
      gap_q     <= '0;
      poll_q    <= '0;
      sk_q      <= 1'b0;
      cs_q      <= 1'b0;
      prog_q    <= 1'b0;
      rd_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          tx_q      <= f_bits;
          tx_left_q <= f_len;
          rx_left_q <= f_rd ? rx_total : '0;
          prog_q    <= f_prog;
          rd_q      <= f_rd;
          err_q     <= 1'b0;
          cs_q      <= 1'b1;
          sk_q      <= 1'b0;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q <= 1'b0;
            tx_q <= tx_q << 1;
            if (tx_left_q != '0) tx_left_q <= tx_left_q - TXC_W'(1);
            else                 rx_left_q <= rx_left_q - RXC_W'(1);
            if (last_bit) begin
              cs_q    <= 1'b0;
              gap_q   <= '0;
              state_q <= prog_q ? ST_GAP_PROG : ST_GAP_END;
            end
          end
        end
        ST_GAP_PROG: begin
          if (gap_q == GAP_W'(CSMIN_CYC - 1)) begin
            cs_q    <= 1'b1;
            poll_q  <= '0;
            state_q <= ST_POLL;
          end else gap_q <= gap_q + GAP_W'(1);
        end
        ST_POLL: if (tick) begin
          if (mw_do) begin
            tx_q    <= {1'b1, {(FRAME_W-1){1'b0}}};
            state_q <= ST_REL;
          end else if (poll_q == PC_W'(POLL_MAX - 1)) begin
            err_q   <= 1'b1;
            cs_q    <= 1'b0;
            gap_q   <= '0;
            state_q <= ST_GAP_END;
          end else poll_q <= poll_q + PC_W'(1);
        end
        ST_REL: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q    <= 1'b0;
            tx_q    <= '0;
            cs_q    <= 1'b0;
            gap_q   <= '0;
            state_q <= ST_GAP_END;
          end
        end
        ST_GAP_END: begin
          if (gap_q == GAP_W'(CSMIN_CYC - 1)) state_q <= ST_IDLE;
          else gap_q <= gap_q + GAP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mw_cs       = cs_q;
  assign mw_sk       = sk_q;
  assign mw_di       = tx_q[FRAME_W-1];
  assign err_timeout = err_q;

  // R7: clock only pulses inside a select session
  a_r7_sk_only_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sk |-> mw_cs);
  // R3: data line held across each rising clock edge
  a_r3_di_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sk) |-> $stable(mw_di));
  // R2: idle controller never holds select
  a_r2_no_cs_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mw_cs);
  // R2: taking a command removes ready on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R8 / R11: a select drop is never a single-cycle glitch
  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |=> !mw_cs);
  // R10: timeout flag appears only with select released
  a_r10_err_with_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> !mw_cs);
endmodule

// File: tb/mw_host_bench.sv
module mw_host_bench;
  import mw_pkg::*;
  localparam int HALF  = 2;
  localparam int CSMIN = 3;
  localparam int PMAX  = 16;
  localparam int BUSY  = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, rd_valid, err_timeout, mw_cs, mw_sk, mw_di, mw_do;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [15:0] cmd_wdata, rd_data;
  logic [7:0] cmd_count;

  always #10 clk = ~clk;

  mw_host #(.HALF_CYC(HALF), .CSMIN_CYC(CSMIN), .POLL_MAX(PMAX), .CNT_W(8)) u_mw_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_timeout(err_timeout),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit hang = 0;
  logic [15:0] exp_mem [128];

  // ---------------- memory model ----------------
  logic [15:0] dev_mem [128];
  logic m_psk, m_pcs, m_status, m_wen, m_started, m_read;
  int m_busy, m_kind, m_nb, m_pos, sess, frame_bits, rel_ok, rel_bad, n_sess;
  logic [31:0] m_sr;
  logic [1:0] m_op;
  logic [7:0] m_af;
  logic [6:0] m_addr;
  logic [15:0] m_word, m_data;
  logic ready_now;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) dev_mem[i] = 16'hFFFF;
      m_psk = 0; m_pcs = 0; m_status = 0; m_wen = 0; m_started = 0; m_read = 0;
      m_busy = 0; m_kind = 0; m_nb = 0; m_pos = 0; sess = 0; frame_bits = 0;
      rel_ok = 0; rel_bad = 0; n_sess = 0; m_sr = 0;
      mw_do <= 1'b0;
    end else begin
      ready_now = (m_busy == 0) && !hang;
      if (m_busy > 0) m_busy--;
      if (mw_cs && !m_pcs) begin
        sess = 0; m_started = 0; m_nb = 0; m_read = 0; n_sess++;
        mw_do <= m_status ? ready_now : 1'b0;
      end else if (mw_cs && m_status) mw_do <= ready_now;
      if (mw_cs && mw_sk && !m_psk) begin
        sess++;
        if (m_status) begin
          if (mw_di) rel_ok++; else rel_bad++;
          m_status = 0;
          mw_do <= 1'b0;
        end else if (m_read) begin
          mw_do <= m_word[15 - m_pos];
          if (m_pos == 15) begin
            m_addr = m_addr + 7'd1;
            m_word = dev_mem[m_addr];
            m_pos = 0;
          end else m_pos++;
        end else if (!m_started) begin
          if (mw_di) begin m_started = 1; m_nb = 0; end
        end else begin
          m_sr = {m_sr[30:0], mw_di};
          m_nb++;
          if (m_nb == 10) begin
            m_op = m_sr[9:8]; m_af = m_sr[7:0];
            case (m_op)
              2'b10: begin
                m_read = 1; m_addr = m_af[6:0]; m_word = dev_mem[m_addr]; m_pos = 0;
                mw_do <= 1'b0;
              end
              2'b11: m_kind = 2;
              2'b00: case (m_af[7:6])
                2'b11: m_wen = 1;
                2'b00: m_wen = 0;
                2'b10: m_kind = 3;
                default: ;
              endcase
              default: ;
            endcase
          end
          if (m_nb == 26) begin
            m_data = m_sr[15:0];
            if (m_op == 2'b01) m_kind = 1;
            else if (m_op == 2'b00 && m_af[7:6] == 2'b01) m_kind = 4;
          end
        end
      end
      if (!mw_cs && m_pcs) begin
        if (m_started) frame_bits = sess;
        m_status = 0;
        if (m_kind != 0) begin
          if (m_wen) begin
            case (m_kind)
              1: dev_mem[m_af[6:0]] = m_data;
              2: dev_mem[m_af[6:0]] = 16'hFFFF;
              3: for (int i = 0; i < 128; i++) dev_mem[i] = 16'hFFFF;
              default: for (int i = 0; i < 128; i++) dev_mem[i] = m_data;
            endcase
            m_busy = BUSY;
          end
          m_status = 1;
          m_kind = 0;
        end
        mw_do <= 1'b0;
      end
      m_psk = mw_sk; m_pcs = mw_cs;
    end
  end

  // ---------------- monitors ----------------
  logic [15:0] got [256];
  int got_n = 0;
  always @(posedge clk) if (rst_n && rd_valid) begin
    got[got_n[7:0]] <= rd_data;
    got_n <= got_n + 1;
  end

  logic p_sk = 0, p_cs = 0;
  int since = 0, sk_bad = 0, sk_edges = 0, low_cnt = 0, min_low = 1000;
  bit have_edge = 0, cs_seen = 0;
  always @(posedge clk) if (rst_n) begin
    if (mw_sk && !mw_cs) sk_bad++;
    if (mw_cs && p_cs) begin
      if (mw_sk != p_sk) begin
        if (have_edge && since != HALF) sk_bad++;
        sk_edges++; have_edge = 1; since = 1;
      end else since++;
    end else begin have_edge = 0; since = 1; end
    if (!mw_cs) low_cnt++;
    else begin
      if (!p_cs && cs_seen && low_cnt < min_low) min_low = low_cnt;
      cs_seen = 1; low_cnt = 0;
    end
    p_sk = mw_sk; p_cs = mw_cs;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  int r2_bad = 0;
  task automatic run_cmd(input logic [2:0] op, input logic [6:0] a,
                         input logic [15:0] d, input logic [7:0] n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_count = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (cmd_ready) r2_bad++;
    while (!cmd_ready) begin
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input int a, input int n, input string req);
    int base, eff;
    base = got_n;
    eff = (n == 0) ? 1 : n;
    run_cmd(OP_READ, 7'(a), 16'h0, 8'(n));
    chk(got_n - base == eff, req, got_n - base, eff);
    for (int i = 0; i < eff; i++)
      chk(got[(base + i) & 255] == exp_mem[(a + i) % 128], req,
          got[(base + i) & 255], exp_mem[(a + i) % 128]);
  endtask

  int exp_rel = 0;

  initial begin
    int s0, r0;
    int addrs [10];
    logic [15:0] d;
    void'($urandom(32'd20240918));
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_wdata = 0; cmd_count = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!mw_cs && !mw_sk && !mw_di, "R1", {mw_cs, mw_sk, mw_di}, 0);
    chk(cmd_ready && !rd_valid && !err_timeout, "R1", {cmd_ready, rd_valid, err_timeout}, 4);

    // R4: write while disabled is dropped; R5 frame length
    run_cmd(OP_WRITE, 7'd5, 16'h1234, 0); exp_rel++;
    chk(frame_bits == 27, "R5", frame_bits, 27);
    read_chk(5, 1, "R4");
    chk(frame_bits == 28, "R6", frame_bits, 28);

    // R4/R11 enable: one session, 11 bits
    s0 = n_sess;
    run_cmd(OP_WREN, 0, 0, 0);
    chk(n_sess - s0 == 1, "R11", n_sess - s0, 1);
    chk(frame_bits == 11, "R4", frame_bits, 11);

    // R8/R3 random writes
    for (int k = 0; k < 10; k++) begin
      addrs[k] = int'($urandom % 128);
      d = 16'($urandom);
      s0 = n_sess;
      run_cmd(OP_WRITE, 7'(addrs[k]), d, 0); exp_rel++;
      exp_mem[addrs[k]] = d;
      chk(n_sess - s0 == 2, "R8", n_sess - s0, 2);
    end
    for (int k = 0; k < 10; k++) read_chk(addrs[k], 1, "R3");

    // R6 streamed reads of random length
    for (int k = 0; k < 6; k++) read_chk(int'($urandom % 128), int'($urandom % 5) + 1, "R6");

    // R3 erase
    run_cmd(OP_ERASE, 7'(addrs[0]), 0, 0); exp_rel++;
    exp_mem[addrs[0]] = 16'hFFFF;
    chk(frame_bits == 11, "R3", frame_bits, 11);
    read_chk(addrs[0], 1, "R3");

    // R6 wrap and zero count
    read_chk(126, 4, "R6");
    read_chk(10, 0, "R6");

    // R4 disable then write ignored
    run_cmd(OP_WRDIS, 0, 0, 0);
    run_cmd(OP_WRITE, 7'd20, 16'hBEEF, 0); exp_rel++;
    read_chk(20, 1, "R4");

    // R4 erase all, R5 write all
    run_cmd(OP_WREN, 0, 0, 0);
    run_cmd(OP_ERALL, 0, 0, 0); exp_rel++;
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hFFFF;
    read_chk(0, 128, "R4");
    run_cmd(OP_WRALL, 0, 16'hA5C3, 0); exp_rel++;
    chk(frame_bits == 27, "R5", frame_bits, 27);
    for (int i = 0; i < 128; i++) exp_mem[i] = 16'hA5C3;
    read_chk(int'($urandom % 128), 3, "R5");

    // R10 timeout
    hang = 1;
    r0 = rel_ok;
    run_cmd(OP_WRITE, 7'd40, 16'h1357, 0);
    exp_mem[40] = 16'h1357;
    chk(err_timeout == 1'b1, "R10", err_timeout, 1);
    chk(rel_ok == r0, "R10", rel_ok, r0);
    hang = 0;
    read_chk(40, 1, "R10");
    chk(err_timeout == 1'b0, "R10", err_timeout, 0);

    // monitors
    chk(rel_ok == exp_rel && rel_bad == 0, "R9", rel_ok, exp_rel);
    chk(sk_bad == 0 && sk_edges > 0, "R7", sk_bad, 0);
    chk(min_low >= CSMIN, "R8", min_low, CSMIN);
    chk(r2_bad == 0, "R2", r2_bad, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule